// File: doc/BRIEF.md
# Byte-Wise Table Access Unit for Word-Organised Program Memory

This block lets a processor core move single bytes between its registers and a program memory that stores 16-bit words. It keeps a 21-bit byte pointer and an 8-bit data latch. The top 20 pointer bits select a memory word and the lowest bit selects one byte of that word. A read command fetches the word through a synchronous read port and copies the selected byte into the latch. A write command copies the latch into the selected half of a 16-bit holding word and leaves the other half as it was. The flash programming step that would consume that holding word is outside this block.

Read and write commands can update the pointer in one of four ways: leave it, step it forward after the access, step it back after the access, or step it forward before the access. Every step wraps modulo 2^21. A read takes two cycles. A busy flag covers the second cycle, and any command presented during that cycle is ignored.

Top module: `tblx_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, the pointer, latch, holding word and busy flag all read zero.
- R2: Command code 3 (load pointer) stores ptr_wdata into the pointer on the next clock edge and leaves the latch and holding word unchanged.
- R3: Pointer bit 0 picks the byte: 0 selects word bits [7:0] and 1 selects word bits [15:8]. The memory word address driven on mem_addr is the effective pointer bits [20:1].
- R4: Command code 1 (read) drives mem_rd_en high in the same cycle. busy is high during the following cycle, and the selected byte is visible on latch one cycle after that.
- R5: Any command presented while busy is high has no effect on the pointer, latch or holding word, and it issues no memory read.
- R6: cmd_mode applies to reads and writes. Code 0 leaves the pointer unchanged. Code 1 accesses the pointer and then adds 1. Code 2 accesses the pointer and then subtracts 1. Code 3 adds 1 first and accesses the new value. All arithmetic wraps modulo 2^21.
- R7: Command code 2 (write) puts the latch byte into the half of hold_word selected by the effective pointer bit 0. The other half is left as it was, and no memory read is issued.
- R8: Command code 4 (load latch) stores latch_wdata into the latch on the next clock edge and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command: 0 idle, 1 read, 2 write, 3 load pointer, 4 load latch |
| cmd_mode | input | 2 | Pointer update mode for reads and writes |
| ptr_wdata | input | 21 | Value for load pointer |
| latch_wdata | input | 8 | Value for load latch |
| mem_rd_en | output | 1 | Synchronous word read request |
| mem_addr | output | 20 | Word address |
| mem_rdata | input | 16 | Word returned one cycle after the request |
| busy | output | 1 | High in the cycle in which a read completes |
| ptr | output | 21 | Current byte pointer |
| latch | output | 8 | Table data latch |
| hold_word | output | 16 | Holding word built up by writes |

## Verification
Reads run over a series of pointer values that alternate bit 0 within the same memory word. This separates the low and high byte lanes and shows that the word address is bit 0 dropped rather than the full pointer. All four update modes are applied around both ends of the 21-bit range, which separates post-access from pre-access addressing and checks the wrap in each direction. Writes into both halves of the holding word, followed by a busy-cycle command, show that merges keep the other half and that commands presented while busy are dropped.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_LDPTR = 3'd3,
        OP_LDLAT = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        MD_KEEP = 2'd0,
        MD_POST_INC = 2'd1,
        MD_POST_DEC = 2'd2,
        MD_PRE_INC  = 2'd3
    } mode_e;

endpackage

// File: rtl/tblx_ptr_step.sv
module tblx_ptr_step #(
    parameter int PTR_W = 21
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [1:0]       mode,
    output logic [PTR_W-1:0] eff,
    output logic [PTR_W-1:0] nxt
);
    import tblx_pkg::*;

    logic [PTR_W-1:0] plus_one;
    logic [PTR_W-1:0] minus_one;

    assign plus_one  = cur + PTR_W'(1);
    assign minus_one = cur - PTR_W'(1);

    always_comb begin
        eff = cur;
        nxt = cur;
        case (mode_e'(mode))
            MD_POST_INC: nxt = plus_one;
            MD_POST_DEC: nxt = minus_one;
            MD_PRE_INC: begin
                eff = plus_one;
                nxt = plus_one;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tblx_byte_lane.sv
module tblx_byte_lane #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  pick,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic [WORD_W-1:0] word_merged
);
    logic [LANES-1:0][BYTE_W-1:0] lanes_in;
    logic [LANES-1:0][BYTE_W-1:0] lanes_out;

    assign lanes_in    = word_in;
    assign byte_out    = lanes_in[pick];
    assign word_merged = lanes_out;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_out[g] = (pick == SEL_W'(g)) ? byte_in : lanes_in[g];
    end
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit #(
    parameter int PTR_W  = 21,
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int ADDR_W = PTR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_mode,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic [BYTE_W-1:0] latch_wdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] latch,
    output logic [WORD_W-1:0] hold_word
);
    import tblx_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] latch;
        logic [WORD_W-1:0] hold;
        logic              busy;
        logic [SEL_W-1:0]  sel;
    } st_t;

    st_t st_q, st_d;

    logic [PTR_W-1:0]  eff_ptr;
    logic [PTR_W-1:0]  nxt_ptr;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] unused_byte;
    logic [WORD_W-1:0] merged_hold;
    logic [WORD_W-1:0] unused_word;
    op_e               op;
    logic              take_rd, take_wr, take_lp, take_ll;

    assign op      = op_e'(cmd_op);
    assign take_rd = !st_q.busy && (op == OP_READ);
    assign take_wr = !st_q.busy && (op == OP_WRITE);
    assign take_lp = !st_q.busy && (op == OP_LDPTR);
    assign take_ll = !st_q.busy && (op == OP_LDLAT);

    tblx_ptr_step #(.PTR_W(PTR_W)) u_step (
        .cur  (st_q.ptr),
        .mode (cmd_mode),
        .eff  (eff_ptr),
        .nxt  (nxt_ptr)
    );

    // Extract the returned byte using the lane remembered from the request.
    tblx_byte_lane #(.BYTE_W(BYTE_W), .LANES(LANES)) u_rd_lane (
        .word_in     (mem_rdata),
        .pick        (st_q.sel),
        .byte_in     (st_q.latch),
        .byte_out    (rd_byte),
        .word_merged (unused_word)
    );

    // Merge the latch into the holding word at the effective lane.
    tblx_byte_lane #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wr_lane (
        .word_in     (st_q.hold),
        .pick        (eff_ptr[SEL_W-1:0]),
        .byte_in     (st_q.latch),
        .byte_out    (unused_byte),
        .word_merged (merged_hold)
    );

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;
        if (st_q.busy) begin
            st_d.latch = rd_byte;
        end
        if (take_rd) begin
            st_d.busy = 1'b1;
            st_d.sel  = eff_ptr[SEL_W-1:0];
            st_d.ptr  = nxt_ptr;
        end
        if (take_wr) begin
            st_d.hold = merged_hold;
            st_d.ptr  = nxt_ptr;
        end
        if (take_lp) begin
            st_d.ptr = ptr_wdata;
        end
        if (take_ll) begin
            st_d.latch = latch_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rd_en = take_rd;
    assign mem_addr  = eff_ptr[PTR_W-1:SEL_W];
    assign busy      = st_q.busy;
    assign ptr       = st_q.ptr;
    assign latch     = st_q.latch;
    assign hold_word = st_q.hold;

    // R4: the busy flag lasts exactly one cycle after an accepted read.
    a_r4_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> busy);
    a_r4_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R5: state other than the latch does not move during a busy cycle.
    a_r5_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr) && $stable(hold_word));
    a_r5_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_rd_en);

    // R8: the latch changes only by a completed read or a latch load.
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !take_ll) |=> $stable(latch));

    // R7: the holding word changes only on an accepted write.
    a_r7_hold_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        !take_wr |=> $stable(hold_word));

    // R6: post-increment steps the pointer by exactly one with wrap.
    a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_rd || take_wr) && cmd_mode == 2'd1) |=> ptr == $past(ptr) + PTR_W'(1));
endmodule

// File: tb/tblx_unit_tb.sv
module tblx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_mode = 2'd0;
    logic [20:0] ptr_wdata = '0;
    logic [7:0]  latch_wdata = '0;
    logic        mem_rd_en;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy;
    logic [20:0] ptr;
    logic [7:0]  latch;
    logic [15:0] hold_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tblx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
        .ptr_wdata(ptr_wdata), .latch_wdata(latch_wdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .ptr(ptr), .latch(latch), .hold_word(hold_word)
    );

    // Memory model: high byte = addr[7:0]^5A, low byte = addr[7:0]+11.
    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_word(mem_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] md, input logic [20:0] d);
        cmd_op = op; cmd_mode = md; ptr_wdata = d; latch_wdata = d[7:0];
        @(negedge clk);
        cmd_op = 3'd0;
        if (op == 3'd1) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  md;
        logic [20:0] data;
        logic [20:0] exp_ptr;
        logic [7:0]  exp_lat;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd3, 2'd0, 21'h000010, 21'h000010, 8'h00},
        '{3'd1, 2'd1, 21'h0ABCDE, 21'h000011, 8'h19},
        '{3'd1, 2'd1, 21'h000000, 21'h000012, 8'h52},
        '{3'd1, 2'd3, 21'h000000, 21'h000013, 8'h53},
        '{3'd1, 2'd2, 21'h000000, 21'h000012, 8'h53},
        '{3'd1, 2'd0, 21'h000000, 21'h000012, 8'h1A},
        '{3'd3, 2'd0, 21'h1FFFFF, 21'h1FFFFF, 8'h1A},
        '{3'd1, 2'd1, 21'h000000, 21'h000000, 8'hA5},
        '{3'd1, 2'd2, 21'h000000, 21'h1FFFFF, 8'h11},
        '{3'd3, 2'd0, 21'h1FFFFE, 21'h1FFFFE, 8'h11},
        '{3'd1, 2'd3, 21'h000000, 21'h1FFFFF, 8'hA5},
        '{3'd1, 2'd3, 21'h000000, 21'h000000, 8'h11}
    };

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R1 ptr in reset", 32'(ptr), 0);
        chk("R1 latch in reset", 32'(latch), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold after reset", 32'(hold_word), 0);
        chk("R1 busy after reset", 32'(busy), 0);

        // R2 R3 R4 R6: vector table of loads and reads in every mode.
        for (int i = 0; i < 12; i++) begin
            issue(VECS[i].op, VECS[i].md, VECS[i].data);
            chk($sformatf("R6 ptr vec%0d", i), 32'(ptr), 32'(VECS[i].exp_ptr));
            chk($sformatf("R3 latch vec%0d", i), 32'(latch), 32'(VECS[i].exp_lat));
        end

        // R8: latch load, pointer unchanged.
        issue(3'd4, 2'd0, 21'h0000C3);
        chk("R8 latch load", 32'(latch), 32'h C3);
        chk("R8 ptr kept", 32'(ptr), 0);
        // R7: write into low half with post-increment, no memory read.
        cmd_op = 3'd2; cmd_mode = 2'd1;
        #1;
        chk("R7 no read on write", 32'(mem_rd_en), 0);
        @(negedge clk); cmd_op = 3'd0;
        chk("R7 low merge", 32'(hold_word), 32'h00C3);
        chk("R6 write post-inc", 32'(ptr), 1);
        issue(3'd4, 2'd0, 21'h00007E);
        issue(3'd2, 2'd2, 21'h0);
        chk("R7 high merge keeps low", 32'(hold_word), 32'h7EC3);
        chk("R6 write post-dec", 32'(ptr), 0);
        chk("R7 latch kept", 32'(latch), 32'h7E);

        // R4 R5: read timing, then a command during busy is ignored.
        issue(3'd3, 2'd0, 21'h00002A);
        cmd_op = 3'd1; cmd_mode = 2'd0;
        #1;
        chk("R4 rd_en same cycle", 32'(mem_rd_en), 1);
        chk("R3 word address", 32'(mem_addr), 32'h15);
        @(negedge clk);
        cmd_op = 3'd3; ptr_wdata = 21'h000055;
        #1;
        chk("R4 busy cycle", 32'(busy), 1);
        chk("R5 no read while busy", 32'(mem_rd_en), 0);
        @(negedge clk);
        cmd_op = 3'd0;
        chk("R5 ptr unchanged", 32'(ptr), 32'h2A);
        chk("R4 latch ready", 32'(latch), 32'h26);
        chk("R4 busy cleared", 32'(busy), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule